// File: doc/BRIEF.md
# Prescaled 8-bit Overflow Timer

This block is an 8-bit up-counter for a small processor subsystem. A free-running prescaler sets how often it counts. The clock-select field can stop the counter, advance it on every clock, or divide the system clock by 8, 64, 256 or 1024. When the counter moves past 0xFF it returns to 0x00 and sets an overflow flag. Software reaches four byte-wide registers through a simple single-cycle register bus. Writes take effect on the clock edge while the select and write strobes are high. Reads return data combinationally.

The interrupt request is the overflow flag gated by the overflow-enable mask bit and by the global interrupt-enable input, which comes from outside the block. While the request is high the block presents a fixed vector address. An acknowledge pulse takes the interrupt. Taking it clears the flag in hardware and raises an entry-busy indication for exactly two clock cycles, which stands for the cost of entering the handler.

The reset input is asserted asynchronously and active low, and inside the block its release is synchronised to the clock.

Top module: `ovf_timer8`

## Requirements
- R1: A clock-select value of 0, 6 or 7 stops the counter: the count register keeps its value for any number of clocks.
- R2: A clock-select value of 1 increments the counter by one on every clock edge.
- R3: Clock-select values 2, 3, 4 and 5 increment the counter once every 8, 64, 256 and 1024 clocks. The dividing prescaler runs freely, and a new select value takes effect at its next tick without restarting it.
- R4: When the counter is at 0xFF and advances, it becomes 0x00 and bit 0 of the flag register (address 0x35) becomes 1.
- R5: `irq_req` is high only when the overflow flag, bit 0 of the mask register (address 0x6E) and `gie_i` are all 1. If either enable is 0, no request is made and the flag stays set.
- R6: An `irq_ack` pulse while `irq_req` is high clears the flag on that clock edge, so the request is low in the next cycle. An `irq_ack` pulse while `irq_req` is low changes nothing.
- R7: While `irq_req` is high, `irq_vector` is 0x0020, and it is 0 otherwise. After a taken acknowledge, `entry_busy` is high for exactly two cycles.
- R8: Writing a value with bit 0 set to the flag register clears the flag. Writing a value with bit 0 clear leaves the flag unchanged.
- R9: A bus write to the count register (address 0x46) loads the written value. The write wins over an increment in the same cycle, and that cycle sets no overflow.
- R10: Reset clears all four registers and leaves `irq_req`, `irq_vector` and `entry_busy` low. The control register (address 0x45) holds clock select in bits 2:0, and the mask register uses only bit 0. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| gie_i | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Overflow interrupt request |
| irq_vector | output | 16 | Vector address while the request is high |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| entry_busy | output | 1 | High for the two interrupt-entry cycles |

## Verification
A prescaler that is out of phase or wrongly decoded shows at the count register within one period of the selected divisor. It shows either as an early increment at the 63rd clock under divide-by-64 or as a count that moves under a stopped code. A wrong flag state shows on `irq_req` in the same cycle that the two enables are set. A wrong priority between the flag's set and clear sources shows when the flag register is read one cycle after the ack or the write. An entry counter with the wrong length shows on `entry_busy` on the third cycle after the ack.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

  localparam int unsigned PRE_W = 10;

  typedef enum logic [2:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5,
    CS_RSV6    = 3'd6,
    CS_RSV7    = 3'd7
  } clk_sel_e;

endpackage

// File: rtl/ovf_timer_rst_sync.sv
module ovf_timer_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/ovf_timer_prescaler.sv
module ovf_timer_prescaler
  import ovf_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_sel_e cs_i,
  output logic     tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             tick;

  // free-running divider, never reset by a select change
  always_comb pre_d = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  always_comb begin
    unique case (cs_i)
      CS_DIV1:    tick = 1'b1;
      CS_DIV8:    tick = &pre_q[2:0];
      CS_DIV64:   tick = &pre_q[5:0];
      CS_DIV256:  tick = &pre_q[7:0];
      CS_DIV1024: tick = &pre_q[9:0];
      default:    tick = 1'b0;
    endcase
  end

  assign tick_o = tick;
endmodule

// File: rtl/ovf_timer_core.sv
module ovf_timer_core
  import ovf_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_CTRL = 8'h45,
  parameter logic [ADDR_W-1:0] A_CNT  = 8'h46,
  parameter logic [ADDR_W-1:0] A_FLAG = 8'h35,
  parameter logic [ADDR_W-1:0] A_MASK = 8'h6E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              ack_take_i,
  output clk_sel_e          cs_o,
  output logic              flag_o,
  output logic              mask_o
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;
  localparam logic [DATA_W-1:0] CNT_ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  clk_sel_e          cs_q, cs_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              flag_q, flag_d;
  logic              mask_q, mask_d;

  logic wr_ctrl, wr_cnt, wr_flag, wr_mask;
  logic ovf_set, flag_clr;

  always_comb begin
    wr_ctrl = sel_i && we_i && (addr_i == A_CTRL);
    wr_cnt  = sel_i && we_i && (addr_i == A_CNT);
    wr_flag = sel_i && we_i && (addr_i == A_FLAG);
    wr_mask = sel_i && we_i && (addr_i == A_MASK);
  end

  // next-state
  always_comb begin
    cs_d   = wr_ctrl ? clk_sel_e'(wdata_i[2:0]) : cs_q;
    mask_d = wr_mask ? wdata_i[0] : mask_q;

    if (wr_cnt)      cnt_d = wdata_i;
    else if (tick_i) cnt_d = cnt_q + CNT_ONE;
    else             cnt_d = cnt_q;

    ovf_set  = tick_i && !wr_cnt && (cnt_q == CNT_MAX);
    flag_clr = (wr_flag && wdata_i[0]) || ack_take_i;

    if (ovf_set)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= CS_STOP;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      if (addr_i == A_CTRL)      rdata_o[2:0] = cs_q;
      else if (addr_i == A_CNT)  rdata_o      = cnt_q;
      else if (addr_i == A_FLAG) rdata_o[0]   = flag_q;
      else if (addr_i == A_MASK) rdata_o[0]   = mask_q;
    end
  end

  assign cs_o   = cs_q;
  assign flag_o = flag_q;
  assign mask_o = mask_q;

  // R1: stopped codes hold the count
  p_hold_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_q == CS_STOP || cs_q == CS_RSV6 || cs_q == CS_RSV7) && !wr_cnt) |=> $stable(cnt_q));

  // R2: divide-by-1 advances every edge
  p_div1_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q == CS_DIV1 && !wr_cnt) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R4: wrap sets the flag
  p_wrap_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt && cnt_q == CNT_MAX) |=> (cnt_q == '0 && flag_q));

  // R5: without a clear source the flag stays set
  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_take_i && !(wr_flag && wdata_i[0])) |=> flag_q);

  // R6: a taken ack clears the flag unless an overflow lands at once
  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take_i && !ovf_set) |=> !flag_q);

  // R9: count write wins over increment
  p_wr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_q == $past(wdata_i) && flag_q == $past(flag_d)));
endmodule

// File: rtl/ovf_timer_irq.sv
module ovf_timer_irq #(
  parameter int unsigned VEC_W        = 16,
  parameter logic [VEC_W-1:0] VECTOR  = 16'h0020,
  parameter int unsigned ENTRY_CYCLES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_i,
  input  logic             mask_i,
  input  logic             gie_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             take_o,
  output logic             busy_o
);
  localparam int unsigned ENT_W = $clog2(ENTRY_CYCLES + 1);
  localparam logic [ENT_W-1:0] ENT_LOAD = ENT_W'(ENTRY_CYCLES);
  localparam logic [ENT_W-1:0] ENT_ONE  = {{(ENT_W-1){1'b0}}, 1'b1};

  logic             req, take;
  logic [ENT_W-1:0] ent_q, ent_d;

  always_comb begin
    req  = flag_i && mask_i && gie_i;
    take = req && ack_i;
    if (take)             ent_d = ENT_LOAD;
    else if (ent_q != '0) ent_d = ent_q - ENT_ONE;
    else                  ent_d = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else         ent_q <= ent_d;
  end

  assign req_o    = req;
  assign take_o   = take;
  assign vector_o = req ? VECTOR : '0;
  assign busy_o   = (ent_q != '0);

  // R7: two entry cycles after a taken ack
  p_entry_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> busy_o ##1 busy_o);

  // R7: busy ends after the second cycle when nothing is taken again
  p_entry_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !take && $past(busy_o) && !$past(take)) |=> !busy_o);
endmodule

// File: rtl/ovf_timer8.sv
module ovf_timer8
  import ovf_timer_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned VEC_W        = 16,
  parameter logic [VEC_W-1:0] VECTOR  = 16'h0020,
  parameter int unsigned ENTRY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gie_i,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack,
  output logic              entry_busy
);
  logic     rst_sn;
  logic     tick, take, flag, mask;
  clk_sel_e cs;

  ovf_timer_rst_sync u_rst (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  ovf_timer_prescaler u_pre (
    .clk_i  (clk),
    .rst_ni (rst_sn),
    .cs_i   (cs),
    .tick_o (tick)
  );

  ovf_timer_core #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_core (
    .clk_i      (clk),
    .rst_ni     (rst_sn),
    .sel_i      (bus_sel),
    .we_i       (bus_we),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .rdata_o    (bus_rdata),
    .tick_i     (tick),
    .ack_take_i (take),
    .cs_o       (cs),
    .flag_o     (flag),
    .mask_o     (mask)
  );

  ovf_timer_irq #(
    .VEC_W        (VEC_W),
    .VECTOR       (VECTOR),
    .ENTRY_CYCLES (ENTRY_CYCLES)
  ) u_irq (
    .clk_i    (clk),
    .rst_ni   (rst_sn),
    .flag_i   (flag),
    .mask_i   (mask),
    .gie_i    (gie_i),
    .ack_i    (irq_ack),
    .req_o    (irq_req),
    .vector_o (irq_vector),
    .take_o   (take),
    .busy_o   (entry_busy)
  );

  // R5: a request needs all three conditions
  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_req |-> (flag && mask && gie_i));
endmodule

// File: tb/ovf_timer8_tb_top.sv
`timescale 1ns/1ps
module ovf_timer8_tb_top;
  localparam logic [7:0] A_CTRL = 8'h45;
  localparam logic [7:0] A_CNT  = 8'h46;
  localparam logic [7:0] A_FLAG = 8'h35;
  localparam logic [7:0] A_MASK = 8'h6E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        gie_i, irq_req, irq_ack, entry_busy;
  logic [15:0] irq_vector;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ovf_timer8 dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .gie_i      (gie_i),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .irq_ack    (irq_ack),
    .entry_busy (entry_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic make_flag();
    bus_wr(A_CTRL, 8'd0);
    bus_wr(A_CNT, 8'hFF);
    bus_wr(A_CTRL, 8'd1);
    bus_wr(A_CTRL, 8'd0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(A_CTRL, v); chk("R10 ctrl reset", v, 8'h00);
    bus_rd(A_CNT, v);  chk("R10 cnt reset", v, 8'h00);
    bus_rd(A_FLAG, v); chk("R10 flag reset", v, 8'h00);
    bus_rd(A_MASK, v); chk("R10 mask reset", v, 8'h00);
    chk("R10 irq reset", irq_req, 1'b0);
    chk("R10 vector reset", irq_vector, 16'h0);
    chk("R10 busy reset", entry_busy, 1'b0);
    bus_wr(A_CTRL, 8'hFF);
    bus_rd(A_CTRL, v); chk("R10 ctrl unused bits", v, 8'h07);
    bus_wr(A_MASK, 8'hFF);
    bus_rd(A_MASK, v); chk("R10 mask unused bits", v, 8'h01);
    bus_wr(A_MASK, 8'h00);
    bus_wr(A_CTRL, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v0, v1;
    bus_wr(A_CNT, 8'h5A);
    bus_rd(A_CNT, v0); chk("R9 count load", v0, 8'h5A);
    repeat (300) @(negedge clk);
    bus_rd(A_CNT, v1); chk("R1 stop code 0", v1, v0);
    bus_wr(A_CTRL, 8'd6);
    repeat (1100) @(negedge clk);
    bus_rd(A_CNT, v1); chk("R1 stop code 6", v1, v0);
    bus_wr(A_CTRL, 8'd7);
    repeat (1100) @(negedge clk);
    bus_rd(A_CNT, v1); chk("R1 stop code 7", v1, v0);
    bus_wr(A_CTRL, 8'd0);
  endtask

  task automatic t_div1();
    logic [7:0] v;
    bus_wr(A_CNT, 8'h10);
    bus_wr(A_CTRL, 8'd1);
    bus_rd(A_CNT, v); chk("R2 first edge uses old select", v, 8'h10);
    @(negedge clk);
    bus_rd(A_CNT, v); chk("R2 one step", v, 8'h11);
    repeat (3) @(negedge clk);
    bus_rd(A_CNT, v); chk("R2 four steps", v, 8'h14);
    bus_wr(A_CTRL, 8'd0);
  endtask

  task automatic t_divn();
    int divs[4]  = '{8, 64, 256, 1024};
    int codes[4] = '{2, 3, 4, 5};
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v0, v, vn;
      int waited;
      bus_wr(A_CTRL, 8'(codes[i]));
      bus_rd(A_CNT, v0);
      v = v0;
      waited = 0;
      while (v == v0 && waited < 1100) begin
        @(negedge clk);
        bus_rd(A_CNT, v);
        waited++;
      end
      chk($sformatf("R3 div%0d ticks at all", divs[i]), 32'(v != v0), 32'd1);
      repeat (divs[i] - 1) @(negedge clk);
      bus_rd(A_CNT, vn);
      chk($sformatf("R3 div%0d holds before period", divs[i]), vn, v);
      @(negedge clk);
      bus_rd(A_CNT, vn);
      chk($sformatf("R3 div%0d steps on period", divs[i]), vn, v + 8'd1);
    end
    bus_wr(A_CTRL, 8'd0);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    bus_wr(A_FLAG, 8'h01);
    bus_wr(A_CNT, 8'hFF);
    bus_wr(A_CTRL, 8'd1);
    bus_rd(A_CNT, v);  chk("R4 before wrap cnt", v, 8'hFF);
    bus_rd(A_FLAG, v); chk("R4 before wrap flag", v, 8'h00);
    @(negedge clk);
    bus_rd(A_CNT, v);  chk("R4 wrap to zero", v, 8'h00);
    bus_rd(A_FLAG, v); chk("R4 overflow flag set", v, 8'h01);
    bus_wr(A_CTRL, 8'd0);
    bus_wr(A_FLAG, 8'h01);
  endtask

  task automatic t_wr_priority();
    logic [7:0] v;
    bus_wr(A_CTRL, 8'd1);
    bus_wr(A_CNT, 8'h80);
    bus_rd(A_CNT, v); chk("R9 write beats increment", v, 8'h80);
    bus_wr(A_CTRL, 8'd0);
    bus_wr(A_FLAG, 8'h01);
    bus_wr(A_CNT, 8'hFE);
    bus_wr(A_CTRL, 8'd1);
    bus_wr(A_CNT, 8'hFF);
    bus_wr(A_CNT, 8'h40);
    bus_rd(A_CNT, v);  chk("R9 write at 0xFF", v, 8'h40);
    bus_rd(A_FLAG, v); chk("R9 no overflow on write", v, 8'h00);
    bus_wr(A_CTRL, 8'd0);
  endtask

  task automatic t_flag_clear();
    logic [7:0] v;
    make_flag();
    bus_rd(A_FLAG, v); chk("R8 flag set for test", v, 8'h01);
    bus_wr(A_FLAG, 8'h00);
    bus_rd(A_FLAG, v); chk("R8 write 0 keeps flag", v, 8'h01);
    bus_wr(A_FLAG, 8'hFE);
    bus_rd(A_FLAG, v); chk("R8 write 0xFE keeps flag", v, 8'h01);
    bus_wr(A_FLAG, 8'h01);
    bus_rd(A_FLAG, v); chk("R8 write 1 clears flag", v, 8'h00);
  endtask

  task automatic t_gating();
    logic [7:0] v;
    make_flag();
    gie_i = 1'b1;
    bus_wr(A_MASK, 8'h00);
    repeat (5) @(negedge clk);
    chk("R5 mask clear no request", irq_req, 1'b0);
    bus_rd(A_FLAG, v); chk("R5 flag stays with mask clear", v, 8'h01);
    gie_i = 1'b0;
    bus_wr(A_MASK, 8'h01);
    repeat (5) @(negedge clk);
    chk("R5 gie clear no request", irq_req, 1'b0);
    chk("R7 vector low without request", irq_vector, 16'h0);
    bus_rd(A_FLAG, v); chk("R5 flag stays with gie clear", v, 8'h01);
    gie_i = 1'b1;
    #1;
    chk("R5 request with all set", irq_req, 1'b1);
    chk("R7 vector value", irq_vector, 16'h0020);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    @(negedge clk);
    chk("R7 busy low before ack", entry_busy, 1'b0);
    irq_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
    chk("R6 request drops after ack", irq_req, 1'b0);
    bus_rd(A_FLAG, v); chk("R6 ack clears flag", v, 8'h00);
    chk("R7 busy cycle 1", entry_busy, 1'b1);
    @(negedge clk);
    chk("R7 busy cycle 2", entry_busy, 1'b1);
    @(negedge clk);
    chk("R7 busy ends", entry_busy, 1'b0);
    // ack with no request
    gie_i = 1'b0;
    make_flag();
    irq_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_ack = 1'b0;
    bus_rd(A_FLAG, v); chk("R6 ack without request ignored", v, 8'h01);
    @(negedge clk);
    chk("R6 no entry without request", entry_busy, 1'b0);
    bus_wr(A_FLAG, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    gie_i = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stop();
    t_div1();
    t_divn();
    t_wrap();
    t_wr_priority();
    t_flag_clear();
    t_gating();
    t_ack();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule